// File: doc/BRIEF.md
# Weighted Two-Queue Packet Arbiter

This block decides, one packet at a time, whether the next transmit packet comes from the high-priority queue or the low-priority queue. Each queue reports only whether it holds at least one packet. When the packet in flight finishes, the data path pulses `pkt_done`. Decisions are taken only at these packet boundaries. A grant, once issued, stays unchanged until the packet it covers has completed.

The share between the queues is set by a 3-bit weight code, `tx_weight`. The surrounding logic takes it from bits [5:3] of the port configuration word. Code 0 lets one high packet through before each low packet. Codes 1 to 6 let 2×code high packets through (2, 4, 6, 8, 10, 12) before each low packet. Code 7 is strict priority: the low queue is served only when the high queue is empty. A credit counter tracks how many high packets have been sent in the current round. It clears whenever a decision finds the high queue empty, so a queue that drains partway through its share starts a full, fresh round when it refills. If the high queue has used up its credit while the low queue is empty, high packets keep flowing and the credit reloads as if a new round had begun.

Control is a three-state machine:
- `ST_IDLE`: no grant is issued.
- `ST_HIGH`: the high queue is granted.
- `ST_LOW`: the low queue is granted.

From `ST_IDLE` a decision is made on every cycle. From `ST_HIGH` and `ST_LOW` a decision is made only in a cycle with `pkt_done`. Every decision leads to one of the three states:
- pick-high goes to `ST_HIGH`, and may re-enter it.
- pick-low goes to `ST_LOW`, and may re-enter it.
- nothing-ready goes to `ST_IDLE`.

The grant follows one clock after the decision, so back-to-back packets leave no idle cycle.

Top module: `wrr_queue_arbiter`

## Requirements
- R1: While reset is asserted, both grants and the selection are 0. Reset clears the credit, so the first decision after reset is treated as the start of a round.
- R2: With weight code 0 and both queues non-empty, grants alternate: one high packet, then one low packet.
- R3: With weight code c in 1..6 and both queues non-empty, exactly 2×c high packets are granted, followed by one low packet.
- R4: With weight code 7, the high queue wins every decision at which it is non-empty. The low queue is granted only at decisions where the high queue is empty.
- R5: A decision that finds the high queue empty clears the credit. When the high queue is next served, it receives its full share again.
- R6: If the high queue has used its full share and the low queue is empty, high is granted again and its credit restarts at one packet.
- R7: At most one grant is high at any time. The grant does not change until a cycle in which `pkt_done` is 1. `queue_sel` is one-hot or zero, with bit 0 meaning high and bit 1 meaning low.
- R8: A queue that is empty at a decision is not granted. If both are empty, no grant is issued.
- R9: The weight code is read at each decision. A change made before a packet finishes governs the decision taken at its completion.
- R10: The grant for a decision appears in the clock cycle after that decision. Consecutive packets follow with no idle cycle between them.
- R11: `pkt_done` pulses while no grant is active have no effect. No grant appears, and the next round still starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_ready | input | 1 | High-priority queue holds at least one packet |
| lo_ready | input | 1 | Low-priority queue holds at least one packet |
| pkt_done | input | 1 | The granted packet completes in this cycle |
| tx_weight | input | WT_W | Weight code (from bits [5:3] of the port configuration word) |
| grant_hi | output | 1 | High-priority queue supplies the current packet |
| grant_lo | output | 1 | Low-priority queue supplies the current packet |
| queue_sel | output | 2 | One-hot selection: bit 0 high, bit 1 low, 0 when idle |

## Verification
The hardest state to reach is a credit count that diverges from the plain round pattern. One route is a high queue that drains mid-round while the low queue is also empty. The other is a high queue that runs past its full share with no low traffic and must reload. The stimulus reaches both by changing the queue-ready flags and the weight code in the same cycle as `pkt_done`, so that the decision at that boundary sees the new condition. It then refills the queues and checks the length of the following high run against the count a fresh or reloaded round would give. A behavioural model of queue service is compared with the grants on every clock.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        CR_HOLD   = 2'd0,
        CR_CLEAR  = 2'd1,
        CR_STEP   = 2'd2,
        CR_RELOAD = 2'd3
    } credit_op_e;

endpackage

// File: rtl/wrr_weight_decode.sv
module wrr_weight_decode #(
    parameter int WT_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic [WT_W-1:0]  code,
    output logic [CNT_W-1:0] limit,
    output logic             strict
);
    // Code 0 gives a share of one packet; any other code gives twice its value.
    // The all-ones code selects strict priority.
    always_comb begin
        strict = &code;
        if (code == '0) begin
            limit = CNT_W'(1);
        end else begin
            limit = CNT_W'(code) << 1;
        end
    end
endmodule

// File: rtl/wrr_credit_counter.sv
module wrr_credit_counter
    import wrr_arb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  credit_op_e       op,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                CR_CLEAR:  count <= '0;
                CR_STEP:   count <= count + CNT_W'(1);
                CR_RELOAD: count <= CNT_W'(1);
                default:   count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick
    import wrr_arb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             hi_ready,
    input  logic             lo_ready,
    input  logic             strict,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] count,
    output logic             pick_hi,
    output logic             pick_lo,
    output credit_op_e       op
);
    logic spent;

    always_comb begin
        spent   = (count >= limit);
        pick_hi = hi_ready && (strict || !spent || !lo_ready);
        pick_lo = !pick_hi && lo_ready;
        if (strict || !pick_hi) begin
            op = CR_CLEAR;
        end else if (spent) begin
            op = CR_RELOAD;
        end else begin
            op = CR_STEP;
        end
    end
endmodule

// File: rtl/wrr_queue_arbiter.sv
module wrr_queue_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int WT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_ready,
    input  logic            lo_ready,
    input  logic            pkt_done,
    input  logic [WT_W-1:0] tx_weight,
    output logic            grant_hi,
    output logic            grant_lo,
    output logic [1:0]      queue_sel
);
    // Largest share is 2 * (2**WT_W - 2); the counter must hold it.
    localparam int CNT_W = $clog2((1 << WT_W) * 2);

    arb_state_e       state, state_nx, choice;
    credit_op_e       pick_op, credit_op;
    logic [CNT_W-1:0] limit, count;
    logic             strict, pick_hi, pick_lo, boundary;

    wrr_weight_decode #(.WT_W(WT_W), .CNT_W(CNT_W)) u_decode (
        .code   (tx_weight),
        .limit  (limit),
        .strict (strict)
    );

    wrr_pick #(.CNT_W(CNT_W)) u_pick (
        .hi_ready (hi_ready),
        .lo_ready (lo_ready),
        .strict   (strict),
        .limit    (limit),
        .count    (count),
        .pick_hi  (pick_hi),
        .pick_lo  (pick_lo),
        .op       (pick_op)
    );

    wrr_credit_counter #(.CNT_W(CNT_W)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (credit_op),
        .count (count)
    );

    // Boundary: idle, or the packet in flight completes this cycle.
    always_comb begin
        boundary  = (state == ST_IDLE) || pkt_done;
        credit_op = boundary ? pick_op : CR_HOLD;
        if (pick_hi) begin
            choice = ST_HIGH;
        end else if (pick_lo) begin
            choice = ST_LOW;
        end else begin
            choice = ST_IDLE;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:         state_nx = choice;
            ST_HIGH, ST_LOW: state_nx = pkt_done ? choice : state;
            default:         state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        grant_hi  = (state == ST_HIGH);
        grant_lo  = (state == ST_LOW);
        queue_sel = {grant_lo, grant_hi};
    end
endmodule

// File: rtl/wrr_arb_checker.sv
module wrr_arb_checker #(
    parameter int WT_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hi_ready,
    input logic            lo_ready,
    input logic            pkt_done,
    input logic [WT_W-1:0] tx_weight,
    input logic            grant_hi,
    input logic            grant_lo,
    input logic [1:0]      queue_sel
);
    logic at_edge;
    assign at_edge = (!grant_hi && !grant_lo) || pkt_done;

    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_hi && grant_lo));

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(queue_sel));

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_hi && !pkt_done) |=> grant_hi);

    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_lo && !pkt_done) |=> grant_lo);

    assert_no_grant_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && !hi_ready && !lo_ready) |=> (!grant_hi && !grant_lo));

    assert_low_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && !lo_ready) |=> !grant_lo);

    assert_high_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && !hi_ready) |=> !grant_hi);

    assert_strict_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && (&tx_weight) && hi_ready) |=> grant_hi);
endmodule

bind wrr_queue_arbiter wrr_arb_checker u_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_ready  (hi_ready),
    .lo_ready  (lo_ready),
    .pkt_done  (pkt_done),
    .tx_weight (tx_weight),
    .grant_hi  (grant_hi),
    .grant_lo  (grant_lo),
    .queue_sel (queue_sel)
);

// File: tb/test_wrr_queue_arbiter.sv
module test_wrr_queue_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_ready = 1'b0;
    logic       lo_ready = 1'b0;
    logic       pkt_done = 1'b0;
    logic [2:0] tx_weight = 3'd0;
    logic       grant_hi, grant_lo;
    logic [1:0] queue_sel;

    int n_chk = 0;
    int n_bad = 0;
    int got[$];
    int want[$];
    bit finished = 1'b0;

    // reference model state: 0 idle, 1 high, 2 low
    int m_st = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    wrr_queue_arbiter i_wrr_queue_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_ready  (hi_ready),
        .lo_ready  (lo_ready),
        .pkt_done  (pkt_done),
        .tx_weight (tx_weight),
        .grant_hi  (grant_hi),
        .grant_lo  (grant_lo),
        .queue_sel (queue_sel)
    );

    function automatic int cur();
        return grant_hi ? 1 : (grant_lo ? 2 : 0);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural queue-service model.
    always @(posedge clk) begin
        int lim;
        if (!rst_n) begin
            m_st = 0;
            m_cnt = 0;
        end else if (m_st == 0 || pkt_done) begin
            lim = (tx_weight == 0) ? 1 : 2 * int'(tx_weight);
            if (tx_weight == 3'd7) begin
                m_cnt = 0;
                m_st = hi_ready ? 1 : (lo_ready ? 2 : 0);
            end else if (hi_ready && (m_cnt < lim || !lo_ready)) begin
                m_st = 1;
                m_cnt = (m_cnt >= lim) ? 1 : m_cnt + 1;
            end else if (lo_ready) begin
                m_st = 2;
                m_cnt = 0;
            end else begin
                m_st = 0;
                m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk("R1 grant in reset", cur(), 0);
                chk("R1 sel in reset", int'(queue_sel), 0);
            end else begin
                chk("R10 cycle model", cur(), m_st);
                chk("R7 sel vs model", int'(queue_sel), (m_st == 1) ? 1 : ((m_st == 2) ? 2 : 0));
            end
        end
    end

    // Serve one packet; new ready flags and weight take effect with its done pulse.
    task automatic one_pkt(input int len, input bit nh, input bit nl, input logic [2:0] nw);
        int who;
        @(negedge clk);
        while (cur() == 0) @(negedge clk);
        who = cur();
        got.push_back(who);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            chk("R7 grant held", cur(), who);
        end
        @(posedge clk); #2;
        pkt_done = 1'b1;
        hi_ready = nh;
        lo_ready = nl;
        tx_weight = nw;
        @(posedge clk); #2;
        pkt_done = 1'b0;
        if (nh || nl) chk("R10 no gap after done", int'(cur() != 0), 1);
    endtask

    task automatic keep(input int n, input int len);
        for (int i = 0; i < n; i++) one_pkt(len, hi_ready, lo_ready, tx_weight);
    endtask

    task automatic expect_run(input int n, input int who);
        for (int i = 0; i < n; i++) want.push_back(who);
    endtask

    task automatic check_seq(input string req);
        chk({req, " sequence length"}, got.size(), want.size());
        for (int i = 0; i < want.size() && i < got.size(); i++)
            chk({req, " served queue"}, got[i], want[i]);
        got.delete();
        want.delete();
    endtask

    task automatic idle_check(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(req, cur(), 0);
        end
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R11 / R8: done pulses with nothing granted and nothing queued
        pkt_done = 1'b1;
        idle_check("R11 done while idle", 3);
        pkt_done = 1'b0;
        idle_check("R8 both empty", 2);

        // R2 (and R1 fresh round): code 0 alternates
        tx_weight = 3'd0; hi_ready = 1'b1; lo_ready = 1'b1;
        keep(5, 2);
        one_pkt(2, 1'b0, 1'b0, 3'd0);
        for (int i = 0; i < 3; i++) begin expect_run(1, 1); expect_run(1, 2); end
        check_seq("R2");
        idle_check("R8 idle after drain", 2);

        // R3: codes 1..6
        for (int c = 1; c <= 6; c++) begin
            tx_weight = 3'(c); hi_ready = 1'b1; lo_ready = 1'b1;
            keep(2 * c, 1 + (c % 3));
            one_pkt(1, 1'b0, 1'b0, 3'(c));
            expect_run(2 * c, 1);
            expect_run(1, 2);
            check_seq("R3");
            idle_check("R8 between groups", 1);
        end

        // R4: strict priority
        tx_weight = 3'd7; hi_ready = 1'b1; lo_ready = 1'b1;
        keep(10, 1);
        one_pkt(1, 1'b0, 1'b1, 3'd7);
        one_pkt(2, 1'b1, 1'b1, 3'd7);
        one_pkt(1, 1'b0, 1'b0, 3'd7);
        expect_run(11, 1); expect_run(1, 2); expect_run(1, 1);
        check_seq("R4");
        idle_check("R8 after strict", 1);

        // R5: high drains mid-round with low empty, then a fresh round
        tx_weight = 3'd2; hi_ready = 1'b1; lo_ready = 1'b0;
        keep(1, 2);
        one_pkt(2, 1'b0, 1'b0, 3'd2);
        idle_check("R8 high drained", 3);
        hi_ready = 1'b1; lo_ready = 1'b1;
        keep(4, 1);
        one_pkt(1, 1'b0, 1'b0, 3'd2);
        expect_run(6, 1); expect_run(1, 2);
        check_seq("R5");
        idle_check("R8 after R5", 1);

        // R6: share spent with low empty, credit reloads
        tx_weight = 3'd2; hi_ready = 1'b1; lo_ready = 1'b0;
        keep(5, 1);
        one_pkt(1, 1'b1, 1'b1, 3'd2);
        keep(2, 1);
        one_pkt(1, 1'b0, 1'b0, 3'd2);
        expect_run(8, 1); expect_run(1, 2);
        check_seq("R6");
        idle_check("R8 after R6", 1);

        // R9: weight change lands on the next decision
        tx_weight = 3'd0; hi_ready = 1'b1; lo_ready = 1'b1;
        one_pkt(3, 1'b1, 1'b1, 3'd3);
        keep(5, 1);
        one_pkt(1, 1'b0, 1'b0, 3'd3);
        expect_run(6, 1); expect_run(1, 2);
        check_seq("R9");
        idle_check("R8 after R9", 1);

        // R11: done pulses while idle leave the next round fresh
        tx_weight = 3'd1;
        pkt_done = 1'b1;
        idle_check("R11 done while idle again", 2);
        pkt_done = 1'b0;
        hi_ready = 1'b1; lo_ready = 1'b1;
        keep(2, 1);
        one_pkt(1, 1'b0, 1'b0, 3'd1);
        expect_run(2, 1); expect_run(1, 2);
        check_seq("R11");

        // R1: reset in mid-packet drops the grant and clears the credit
        tx_weight = 3'd1; hi_ready = 1'b1; lo_ready = 1'b1;
        keep(1, 1);
        @(negedge clk);
        chk("R1 granted before reset", int'(cur() != 0), 1);
        @(posedge clk); #2 rst_n = 1'b0;
        idle_check("R1 grant dropped", 2);
        rst_n = 1'b1;
        keep(2, 1);
        one_pkt(1, 1'b0, 1'b0, 3'd1);
        expect_run(1, 1);
        expect_run(2, 1); expect_run(1, 2);
        check_seq("R1");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule